// File: doc/BRIEF.md
# External Static Memory Access Sequencer with Wait Stretching

This block carries out one access at a time to a bank of asynchronous static memory. An internal client hands over an address, write data and a direction through a valid/ready handshake. The block then drives the bank's chip select, output enable, write enable, address and data-out lines for as long as the access needs. For a read it returns the captured data with a one-cycle completion pulse. For a write the same pulse tells the client that the bus cycle has finished.

The length of each access is set by a programmable wait-state count held in a single configuration register. A slow device can lengthen an access by pulling an active-low wait line. That line passes through a two-stage synchronizer, so the sequencer reacts to it two clocks after the device drives it. The cycle in which chip select first goes low counts as wait state one. The wait phase lasts for the programmed count or until the synchronized wait line is seen released, whichever comes later. A fixed three-clock completion phase then follows.

A wait assertion only counts if the device drives it no later than the last programmed wait state. The sequencer keeps watching the synchronized line through the first two completion clocks to cover the synchronizer delay. An assertion driven after that window has no effect on the access.

Top module: `extmem_wait_seq`

## Requirements
- R1: While and after reset, with no request, mem_cs_n, mem_oe_n and mem_we_n are 1, mem_dout_en and rsp_done are 0, and req_ready is 1.
- R2: A configuration write stores the wait-state count N clamped to the range 2 to 31: written values 0 and 1 behave as 2, and values above 31 behave as 31.
- R3: With mem_wait_n held at 1, chip select stays low for exactly N+3 consecutive cycles. Cycle 1 is the first cycle with mem_cs_n = 0.
- R4: If mem_wait_n is driven 0 during cycles a through r of an access (cycle 1 is the chip-select cycle, 1 <= a <= N), chip select stays low for max(N, r+2)+3 cycles.
- R5: A mem_wait_n low pulse that begins in cycle N+1 or later has no effect: the access still lasts N+3 cycles.
- R6: During a read, mem_oe_n is 0, mem_we_n is 1 and mem_dout_en is 0 in every chip-select cycle. rsp_rdata in the completion cycle equals mem_din as presented in the last chip-select cycle.
- R7: During a write, mem_we_n is 0, mem_oe_n is 1, mem_dout_en is 1 and mem_dout equals the request's write data in every chip-select cycle.
- R8: mem_addr equals the accepted request address and stays stable in every chip-select cycle.
- R9: rsp_done is 1 for exactly one cycle: the cycle right after the last chip-select cycle, when mem_cs_n is already 1.
- R10: A request is accepted on a clock where req_valid and req_ready are both 1. Chip select goes low in the next cycle. req_ready is 0 in every chip-select cycle, and requests presented then are not taken.
- R11: A configuration write during an access does not change that access's length. It applies from the next accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_wr | input | 1 | Write strobe for the wait-state register |
| cfg_wdata | input | CFG_W | Requested wait-state count, clamped on write |
| req_valid | input | 1 | Access request present |
| req_ready | output | 1 | Sequencer idle and able to take a request |
| req_write | input | 1 | 1 = write access, 0 = read access |
| req_addr | input | ADDR_W | Access address |
| req_wdata | input | DATA_W | Data for a write access |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DATA_W | Read data, valid with rsp_done after a read |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_addr | output | ADDR_W | Address to the memory |
| mem_dout | output | DATA_W | Write data to the memory |
| mem_dout_en | output | 1 | 1 while the data pins should be driven |
| mem_din | input | DATA_W | Read data from the memory |
| mem_wait_n | input | 1 | External wait request, active low, asynchronous |

## Verification
The hardest case to reach is the edge of the window in which a wait assertion is honoured. A pulse that starts in the last programmed wait state must stretch the access. A pulse that starts one cycle later must be ignored, even though it reaches the sequencer through the synchronizer while chip select is still low. The bench reaches this with a memory model that counts chip-select cycles and pulls mem_wait_n low over a chosen cycle window. It drives that window to start at cycle N, at cycle N+1, and in the chip-select cycle with only two wait states programmed. It also releases the line both before and after the programmed count runs out. The model varies mem_din on every cycle, so a read that captures too early or too late returns the wrong value.

// File: rtl/xmw_pkg.sv
package xmw_pkg;

  // Phases of one external access.
  typedef enum logic [1:0] {
    XS_IDLE    = 2'd0,  // no access, request port open
    XS_COUNT   = 2'd1,  // programmed wait states and the fixed tail
    XS_STRETCH = 2'd2,  // device holds the wait line low
    XS_FINISH  = 2'd3   // completion clocks after the wait line is released
  } xs_state_e;

endpackage

// File: rtl/xmw_sync_chain.sv
// Flop chain: a synchronizer for an asynchronous level, or a reset
// release synchronizer when fed a constant 1 and reset to 0.
module xmw_sync_chain #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d[0] = din;
    for (int i = 1; i < STAGES; i++) begin
      chain_d[i] = chain_q[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= {STAGES{RST_VAL}};
    end else begin
      chain_q <= chain_d;
    end
  end

  assign dout = chain_q[STAGES-1];

endmodule

// File: rtl/xmw_ws_cfg.sv
// Wait-state count register; the written value is clamped into range.
module xmw_ws_cfg #(
  parameter int CFG_W    = 6,
  parameter int WS_MIN   = 2,
  parameter int WS_MAX   = 31,
  parameter int WS_RESET = 8,
  parameter int WS_W     = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic [CFG_W-1:0] cfg_wdata,
  output logic [WS_W-1:0]  ws_q
);

  logic [WS_W-1:0] ws_clamped;
  logic [WS_W-1:0] ws_d;

  always_comb begin
    if (cfg_wdata < CFG_W'(WS_MIN)) begin
      ws_clamped = WS_W'(WS_MIN);
    end else if (cfg_wdata > CFG_W'(WS_MAX)) begin
      ws_clamped = WS_W'(WS_MAX);
    end else begin
      ws_clamped = cfg_wdata[WS_W-1:0];
    end
  end

  always_comb begin
    ws_d = ws_q;
    if (cfg_wr) begin
      ws_d = ws_clamped;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ws_q <= WS_W'(WS_RESET);
    end else begin
      ws_q <= ws_d;
    end
  end

endmodule

// File: rtl/xmw_seq_fsm.sv
// Access timing: counts wait states, honours the synchronized wait line
// inside its window, then runs the fixed completion phase.
module xmw_seq_fsm
  import xmw_pkg::*;
#(
  parameter int WS_W  = 5,
  parameter int K_W   = 6,
  parameter int SYNC  = 2,
  parameter int TAIL  = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [WS_W-1:0] ws_cfg,
  input  logic            wait_seen,
  output logic            busy,
  output logic            last,
  output logic            done_q
);

  localparam logic [K_W-1:0] TAIL_K    = K_W'(TAIL);
  localparam logic [K_W-1:0] SYNC_K    = K_W'(SYNC);
  localparam logic [K_W-1:0] TAIL_M1_K = K_W'(TAIL - 1);
  localparam logic [K_W-1:0] ONE_K     = K_W'(1);

  xs_state_e       state_q, state_d;
  logic [K_W-1:0]  k_q, k_d;        // chip-select cycle index, saturating
  logic [K_W-1:0]  rem_q, rem_d;    // completion cycles still to run
  logic [WS_W-1:0] n_q, n_d;        // wait-state count latched per access
  logic            step;

  logic [K_W-1:0]  n_ext;
  logic [K_W-1:0]  lim_end;         // last cycle without any stretching
  logic [K_W-1:0]  lim_seen;        // last cycle a seen wait still counts
  logic [K_W-1:0]  k_inc;
  logic [K_W-1:0]  left;
  logic [K_W-1:0]  rem_start;

  always_comb begin
    n_ext     = K_W'(n_q);
    lim_end   = n_ext + TAIL_K;
    lim_seen  = n_ext + SYNC_K;
    k_inc     = (k_q >= lim_end) ? k_q : k_q + ONE_K;
    left      = (lim_end > k_q) ? (lim_end - k_q) : '0;
    rem_start = (left > TAIL_M1_K) ? left : TAIL_M1_K;
  end

  always_comb begin
    state_d = state_q;
    k_d     = k_q;
    rem_d   = rem_q;
    n_d     = n_q;
    last    = 1'b0;
    unique case (state_q)
      XS_IDLE: begin
        if (start) begin
          state_d = XS_COUNT;
          k_d     = ONE_K;
          n_d     = ws_cfg;
        end
      end
      XS_COUNT: begin
        if (wait_seen && (k_q <= lim_seen)) begin
          state_d = XS_STRETCH;
          k_d     = k_inc;
        end else if (k_q == lim_end) begin
          state_d = XS_IDLE;
          last    = 1'b1;
        end else begin
          k_d = k_inc;
        end
      end
      XS_STRETCH: begin
        k_d = k_inc;
        if (!wait_seen) begin
          state_d = XS_FINISH;
          rem_d   = rem_start;
        end
      end
      XS_FINISH: begin
        if (rem_q == ONE_K) begin
          state_d = XS_IDLE;
          last    = 1'b1;
        end else begin
          rem_d = rem_q - ONE_K;
        end
      end
      default: begin
        state_d = XS_IDLE;
      end
    endcase
  end

  assign busy = (state_q != XS_IDLE);
  assign step = busy | start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= XS_IDLE;
      k_q     <= '0;
      rem_q   <= '0;
      n_q     <= '0;
    end else if (step) begin
      state_q <= state_d;
      k_q     <= k_d;
      rem_q   <= rem_d;
      n_q     <= n_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
    end else begin
      done_q <= last;
    end
  end

endmodule

// File: rtl/xmw_datapath.sv
// Holds the accepted request for the whole access; captures read data.
module xmw_datapath #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              last,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] mem_din,
  output logic              write_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] wdata_q,
  output logic [DATA_W-1:0] rdata_q
);

  logic capture;

  assign capture = last & ~write_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      write_q <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (start) begin
      write_q <= req_write;
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (capture) begin
      rdata_q <= mem_din;
    end
  end

endmodule

// File: rtl/extmem_wait_seq.sv
module extmem_wait_seq #(
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 16,
  parameter int CFG_W       = 6,
  parameter int WS_MIN      = 2,
  parameter int WS_MAX      = 31,
  parameter int WS_RESET    = 8,
  parameter int SYNC_STAGES = 2,
  parameter int TAIL_CYCLES = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [CFG_W-1:0]  cfg_wdata,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_done,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              mem_cs_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dout,
  output logic              mem_dout_en,
  input  logic [DATA_W-1:0] mem_din,
  input  logic              mem_wait_n
);

  localparam int WS_W = $clog2(WS_MAX + 1);
  localparam int K_W  = $clog2(WS_MAX + TAIL_CYCLES + 2);

  logic            srst_n;
  logic            wait_sync_n;
  logic            wait_seen;
  logic [WS_W-1:0] ws_q;
  logic            busy;
  logic            last;
  logic            start;
  logic            write_q;

  xmw_sync_chain #(.STAGES(2), .RST_VAL(1'b0)) i_rst_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (1'b1),
    .dout (srst_n)
  );

  xmw_sync_chain #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) i_wait_sync (
    .clk  (clk),
    .rst_n(srst_n),
    .din  (mem_wait_n),
    .dout (wait_sync_n)
  );

  assign wait_seen = ~wait_sync_n;

  xmw_ws_cfg #(
    .CFG_W   (CFG_W),
    .WS_MIN  (WS_MIN),
    .WS_MAX  (WS_MAX),
    .WS_RESET(WS_RESET),
    .WS_W    (WS_W)
  ) i_cfg (
    .clk      (clk),
    .rst_n    (srst_n),
    .cfg_wr   (cfg_wr),
    .cfg_wdata(cfg_wdata),
    .ws_q     (ws_q)
  );

  assign req_ready = ~busy;
  assign start     = req_valid & req_ready;

  xmw_seq_fsm #(
    .WS_W(WS_W),
    .K_W (K_W),
    .SYNC(SYNC_STAGES),
    .TAIL(TAIL_CYCLES)
  ) i_fsm (
    .clk      (clk),
    .rst_n    (srst_n),
    .start    (start),
    .ws_cfg   (ws_q),
    .wait_seen(wait_seen),
    .busy     (busy),
    .last     (last),
    .done_q   (rsp_done)
  );

  xmw_datapath #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) i_dp (
    .clk      (clk),
    .rst_n    (srst_n),
    .start    (start),
    .last     (last),
    .req_write(req_write),
    .req_addr (req_addr),
    .req_wdata(req_wdata),
    .mem_din  (mem_din),
    .write_q  (write_q),
    .addr_q   (mem_addr),
    .wdata_q  (mem_dout),
    .rdata_q  (rsp_rdata)
  );

  assign mem_cs_n    = ~busy;
  assign mem_oe_n    = ~(busy & ~write_q);
  assign mem_we_n    = ~(busy & write_q);
  assign mem_dout_en = busy & write_q;

endmodule

// File: rtl/xmw_checker.sv
module xmw_checker #(
  parameter int ADDR_W  = 16,
  parameter int MIN_LEN = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              mem_cs_n,
  input logic              mem_oe_n,
  input logic              mem_we_n,
  input logic              mem_dout_en,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              rsp_done
);

  logic [7:0] run_len;
  logic       cs_prev_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_len   <= '0;
      cs_prev_n <= 1'b1;
    end else begin
      cs_prev_n <= mem_cs_n;
      if (!mem_cs_n) begin
        if (cs_prev_n) begin
          run_len <= 8'd1;
        end else if (run_len != 8'hFF) begin
          run_len <= run_len + 8'd1;
        end
      end
    end
  end

  a_r1_idle_strobes: assert property (@(posedge clk) disable iff (!rst_n)
    mem_cs_n |-> (mem_oe_n && mem_we_n && !mem_dout_en));

  a_r6_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_cs_n |-> (mem_oe_n != mem_we_n));

  a_r7_drive_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_cs_n |-> (mem_dout_en == !mem_we_n));

  a_r8_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_cs_n && !cs_prev_n) |-> $stable(mem_addr));

  a_r9_done_after_cs: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |-> (mem_cs_n && !cs_prev_n));

  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done);

  a_r10_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_cs_n |-> !req_ready);

  a_r10_cs_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !mem_cs_n);

  a_r3_min_access: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |-> (run_len >= 8'(MIN_LEN)));

endmodule

bind extmem_wait_seq xmw_checker #(
  .ADDR_W (ADDR_W),
  .MIN_LEN(WS_MIN + TAIL_CYCLES)
) i_xmw_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .mem_cs_n   (mem_cs_n),
  .mem_oe_n   (mem_oe_n),
  .mem_we_n   (mem_we_n),
  .mem_dout_en(mem_dout_en),
  .mem_addr   (mem_addr),
  .rsp_done   (rsp_done)
);

// File: tb/test_extmem_wait_seq.sv
module test_extmem_wait_seq;

  logic        clk;
  logic        rst_n;
  logic        cfg_wr;
  logic [5:0]  cfg_wdata;
  logic        req_valid;
  logic        req_ready;
  logic        req_write;
  logic [15:0] req_addr;
  logic [15:0] req_wdata;
  logic        rsp_done;
  logic [15:0] rsp_rdata;
  logic        mem_cs_n;
  logic        mem_oe_n;
  logic        mem_we_n;
  logic [15:0] mem_addr;
  logic [15:0] mem_dout;
  logic        mem_dout_en;
  logic [15:0] mem_din;
  logic        mem_wait_n;

  int vectors;
  int fails;

  // memory model controls and observations
  bit          wt_en;
  int          wt_a;
  int          wt_r;
  bit          exp_wr;
  logic [15:0] exp_addr;
  logic [15:0] exp_wd;
  int          idx;
  int          last_len;
  logic [15:0] last_din;
  int          viol;
  logic        prev_cs_n;

  extmem_wait_seq i_extmem_wait_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_wr     (cfg_wr),
    .cfg_wdata  (cfg_wdata),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_write  (req_write),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .rsp_done   (rsp_done),
    .rsp_rdata  (rsp_rdata),
    .mem_cs_n   (mem_cs_n),
    .mem_oe_n   (mem_oe_n),
    .mem_we_n   (mem_we_n),
    .mem_addr   (mem_addr),
    .mem_dout   (mem_dout),
    .mem_dout_en(mem_dout_en),
    .mem_din    (mem_din),
    .mem_wait_n (mem_wait_n)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [15:0] pat(input logic [15:0] a);
    return a ^ 16'h5A00;
  endfunction

  // Memory model: numbers the chip-select cycles, drives the wait line
  // over a chosen cycle window and checks the strobes in every cycle.
  always @(negedge clk) begin
    if (!mem_cs_n) begin
      if (prev_cs_n) begin
        idx  = 0;
        viol = 0;
      end
      idx = idx + 1;
      if (mem_addr !== exp_addr) viol++;
      if (exp_wr) begin
        if (mem_we_n !== 1'b0 || mem_oe_n !== 1'b1 || mem_dout_en !== 1'b1 ||
            mem_dout !== exp_wd) viol++;
      end else begin
        if (mem_oe_n !== 1'b0 || mem_we_n !== 1'b1 || mem_dout_en !== 1'b0) viol++;
      end
      mem_wait_n = !(wt_en && idx >= wt_a && idx <= wt_r);
      mem_din    = pat(mem_addr) + 16'(idx);
      last_len   = idx;
      last_din   = mem_din;
    end else begin
      mem_wait_n = 1'b1;
      mem_din    = 16'h0000;
    end
    prev_cs_n = mem_cs_n;
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int exp_len(input int n, input bit en, input int a, input int r);
    int base;
    base = (r + 2 > n) ? r + 2 : n;
    if (en && a >= 1 && a <= n) return base + 3;
    return n + 3;
  endfunction

  task automatic set_ws(input logic [5:0] v);
    @(negedge clk);
    cfg_wr    = 1'b1;
    cfg_wdata = v;
    @(negedge clk);
    cfg_wr    = 1'b0;
  endtask

  // One access; hog keeps a stray request up while busy, cfg_mid writes
  // the wait-state register during the access when it is 0 or more.
  task automatic run_access(input bit wr, input logic [15:0] ad, input logic [15:0] wd,
                            input int n_len, input bit en, input int a, input int r,
                            input bit hog, input int cfg_mid, input string req);
    int exp;
    int cyc;
    exp      = (n_len < 0) ? -n_len : exp_len(n_len, en, a, r);
    wt_en    = en;
    wt_a     = a;
    wt_r     = r;
    exp_wr   = wr;
    exp_addr = ad;
    exp_wd   = wd;
    @(negedge clk);
    chk(req_ready == 1'b1, "R10 ready before request", req_ready, 1);
    req_valid = 1'b1;
    req_write = wr;
    req_addr  = ad;
    req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    chk(mem_cs_n == 1'b0 && req_ready == 1'b0, "R10 cs low after accept",
        {mem_cs_n, req_ready}, 0);
    cyc = 0;
    while (!rsp_done && cyc < 300) begin
      if (hog) begin
        req_valid = 1'b1;
        req_addr  = 16'hDEAD;
        if (!mem_cs_n) chk(req_ready == 1'b0, "R10 not ready while busy", req_ready, 0);
      end
      if (cfg_mid >= 0 && cyc == 0) begin
        cfg_wr    = 1'b1;
        cfg_wdata = 6'(cfg_mid);
      end else begin
        cfg_wr = 1'b0;
      end
      @(negedge clk);
      cyc++;
    end
    req_valid = 1'b0;
    cfg_wr    = 1'b0;
    chk(rsp_done == 1'b1, "R9 done seen", rsp_done, 1);
    chk(mem_cs_n == 1'b1, "R9 cs high in done cycle", mem_cs_n, 1);
    chk(last_len == exp, req, last_len, exp);
    chk(viol == 0, wr ? "R7 R8 write strobes and address" : "R6 R8 read strobes and address",
        viol, 0);
    if (!wr) chk(rsp_rdata == pat(ad) + 16'(exp), "R6 read data from last cycle",
                 rsp_rdata, pat(ad) + 16'(exp));
    @(negedge clk);
    chk(rsp_done == 1'b0, "R9 done single cycle", rsp_done, 0);
    if (hog) begin
      repeat (3) begin
        chk(mem_cs_n == 1'b1, "R10 stray request not taken", mem_cs_n, 1);
        @(negedge clk);
      end
    end
    wt_en = 1'b0;
    repeat (5) @(negedge clk);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(mem_cs_n && mem_oe_n && mem_we_n && !mem_dout_en && !rsp_done && req_ready,
        "R1 reset state", {mem_cs_n, mem_oe_n, mem_we_n, mem_dout_en, rsp_done, req_ready},
        6'b111001);
  endtask

  task automatic t_plain_read;
    set_ws(6'd4);
    run_access(1'b0, 16'h0123, 16'h0, 4, 1'b0, 0, 0, 1'b0, -1, "R3 plain read length N=4");
  endtask

  task automatic t_plain_write;
    set_ws(6'd5);
    run_access(1'b1, 16'h0456, 16'hBEEF, 5, 1'b0, 0, 0, 1'b0, -1, "R3 R7 plain write length N=5");
  endtask

  task automatic t_wait_stretch;
    set_ws(6'd6);
    run_access(1'b0, 16'h1000, 16'h0, 6, 1'b1, 3, 10, 1'b0, -1, "R4 wait beyond count");
  endtask

  task automatic t_wait_short;
    set_ws(6'd10);
    run_access(1'b1, 16'h2000, 16'h1234, 10, 1'b1, 2, 4, 1'b0, -1, "R4 wait within count");
  endtask

  task automatic t_wait_min_ws;
    set_ws(6'd2);
    run_access(1'b0, 16'h3000, 16'h0, 2, 1'b1, 2, 7, 1'b0, -1, "R4 N=2 wait in cycle 2");
    run_access(1'b0, 16'h3004, 16'h0, 2, 1'b1, 1, 1, 1'b0, -1, "R4 N=2 wait in cs cycle");
  endtask

  task automatic t_wait_latest;
    set_ws(6'd5);
    run_access(1'b0, 16'h4000, 16'h0, 5, 1'b1, 5, 9, 1'b0, -1, "R4 wait starting at cycle N");
  endtask

  task automatic t_wait_late;
    set_ws(6'd5);
    run_access(1'b0, 16'h5000, 16'h0, 5, 1'b1, 6, 9, 1'b0, -1, "R5 wait at cycle N+1 ignored");
  endtask

  task automatic t_clamp;
    set_ws(6'd0);
    run_access(1'b0, 16'h6000, 16'h0, 2, 1'b0, 0, 0, 1'b0, -1, "R2 value 0 acts as 2");
    set_ws(6'd1);
    run_access(1'b0, 16'h6001, 16'h0, 2, 1'b0, 0, 0, 1'b0, -1, "R2 value 1 acts as 2");
    set_ws(6'd40);
    run_access(1'b1, 16'h6002, 16'h7777, 31, 1'b0, 0, 0, 1'b0, -1, "R2 value 40 acts as 31");
    set_ws(6'd63);
    run_access(1'b0, 16'h6003, 16'h0, 31, 1'b0, 0, 0, 1'b0, -1, "R2 value 63 acts as 31");
  endtask

  task automatic t_holdoff;
    set_ws(6'd3);
    run_access(1'b0, 16'h7000, 16'h0, 3, 1'b0, 0, 0, 1'b1, -1, "R10 access with stray request");
  endtask

  task automatic t_cfg_mid;
    set_ws(6'd4);
    run_access(1'b0, 16'h8000, 16'h0, 4, 1'b0, 0, 0, 1'b0, 20, "R11 mid-access write ignored");
    run_access(1'b0, 16'h8001, 16'h0, 20, 1'b0, 0, 0, 1'b0, -1, "R11 new count applies next");
  endtask

  initial begin
    vectors   = 0;
    fails     = 0;
    rst_n     = 1'b0;
    cfg_wr    = 1'b0;
    cfg_wdata = '0;
    req_valid = 1'b0;
    req_write = 1'b0;
    req_addr  = '0;
    req_wdata = '0;
    wt_en     = 1'b0;
    wt_a      = 0;
    wt_r      = 0;
    exp_wr    = 1'b0;
    exp_addr  = '0;
    exp_wd    = '0;
    idx       = 0;
    last_len  = 0;
    last_din  = '0;
    viol      = 0;
    prev_cs_n = 1'b1;
    mem_wait_n = 1'b1;
    mem_din    = '0;
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset;
    t_plain_read;
    t_plain_write;
    t_wait_stretch;
    t_wait_short;
    t_wait_min_ws;
    t_wait_latest;
    t_wait_late;
    t_clamp;
    t_holdoff;
    t_cfg_mid;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    vectors++;
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule